// File: doc/BRIEF.md
# Amplifier power mode sequencer

This block sits between the control bits that software writes (standby and speaker mute) plus a shutdown request, and the analog switches that carry them out. It never applies a request the moment it arrives. It reorders the request and holds it back so that switching stays free of audible pops. Standby is released before mute, and mute is released only after a settling window. Standby is never raised while mute is still off. A shutdown walks through mute and standby before the shutdown output is driven.

All delays are counted in pulses of a 1 ms tick input. The tick counts are parameters, so a simulation can use short windows. The block also reports when the charge pump can be treated as settled, and a busy flag that shows the applied state has not yet caught up with the request. Requests are levels. A request that arrives while a window is still running stays pending and takes effect in the cycle after the window closes.

Top module: `amp_pwr_seq`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, stby_o=1, mute_o=1, sd_o=0 and pump_ready_o=0.
- R2: When the standby target is 0 (stby_req_i=0 and sd_req_i=0) and sd_o is 0, stby_o falls at the next clock edge. mute_o stays 1 at that edge.
- R3: A tick is counted when tick_i is 1 at a rising edge while stby_o is 0. The count restarts at every edge where stby_o is 1. mute_o falls only after REL_DLY ticks have been counted since standby was released. mute_o is never 0 while stby_o is 1.
- R4: The mute target is mute_req_i OR the standby target. mute_o rises at the first edge after the mute target becomes 1. stby_o rises only at an edge where mute_o was already 1.
- R5: After a release, stby_o is raised again only once STBY_MIN ticks have been counted. Until then the request stays pending.
- R6: With sd_req_i=1 the order is mute_o first, then stby_o, then sd_o, each change at a later edge than the one before. sd_o falls at the next edge after sd_req_i goes to 0. Standby is released only after sd_o is 0.
- R7: pump_ready_o is 1 exactly when stby_o is 0 and at least PUMP_DLY ticks have been counted. It is 0 in the same cycle that stby_o is 1.
- R8: busy_o is 1 exactly when stby_o, mute_o or sd_o differs from its target. The target of sd_o is sd_req_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse every millisecond |
| stby_req_i | input | 1 | Requested standby (1 = standby) |
| mute_req_i | input | 1 | Requested speaker mute (1 = muted) |
| sd_req_i | input | 1 | Shutdown request |
| stby_o | output | 1 | Applied standby |
| mute_o | output | 1 | Applied speaker mute |
| sd_o | output | 1 | Applied shutdown |
| pump_ready_o | output | 1 | Charge pump treated as settled |
| busy_o | output | 1 | Applied state differs from target |

## Verification
A start-up release is split over several tick bursts. This shows that mute is held one tick short of the window and is released exactly on its last tick. A standby re-request made right after a release tells the minimum-hold window apart from an immediate apply. A request with mute left on tells a requested mute apart from one held only by the window. Shutdown is requested from a fully running state and also from inside the hold window. The first case confirms the mute, standby, shutdown order edge by edge. The second shows that shutdown waits for the hold window.

// File: rtl/amp_pwr_seq_pkg.sv
package amp_pwr_seq_pkg;
  typedef struct packed {
    logic stby;
    logic mute;
    logic sd;
  } mode_t;
endpackage

// File: rtl/amp_pwr_seq_timer.sv
module amp_pwr_seq_timer #(
  parameter int unsigned REL_DLY  = 30,
  parameter int unsigned STBY_MIN = 5,
  parameter int unsigned PUMP_DLY = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic stby_i,
  output logic rel_ok_o,
  output logic min_ok_o,
  output logic pump_ok_o
);
  localparam int unsigned CNT_W = $clog2(REL_DLY + 1);
  localparam logic [CNT_W-1:0] REL_C  = CNT_W'(REL_DLY);
  localparam logic [CNT_W-1:0] MIN_C  = CNT_W'(STBY_MIN);
  localparam logic [CNT_W-1:0] PUMP_C = CNT_W'(PUMP_DLY);

  logic [CNT_W-1:0] cnt_q;

  // ticks since the last standby release, saturating at the longest window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (stby_i)                 cnt_q <= '0;
    else if (tick_i && cnt_q < REL_C) cnt_q <= cnt_q + 1'b1;
  end

  assign rel_ok_o  = cnt_q >= REL_C;
  assign min_ok_o  = cnt_q >= MIN_C;
  assign pump_ok_o = cnt_q >= PUMP_C;

  p_cnt_sat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= REL_C);
  p_cnt_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stby_i |=> cnt_q == '0);
endmodule

// File: rtl/amp_pwr_seq_ctrl.sv
module amp_pwr_seq_ctrl
  import amp_pwr_seq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  stby_req_i,
  input  logic  mute_req_i,
  input  logic  sd_req_i,
  input  logic  rel_ok_i,
  input  logic  min_ok_i,
  output mode_t cur_o,
  output mode_t tgt_o
);
  mode_t cur_q, nxt;

  always_comb begin
    tgt_o.sd   = sd_req_i;
    tgt_o.stby = sd_req_i | stby_req_i;
    tgt_o.mute = tgt_o.stby | mute_req_i;
  end

  always_comb begin
    nxt = cur_q;
    if (!tgt_o.sd)                    nxt.sd = 1'b0;
    else if (cur_q.stby && cur_q.mute) nxt.sd = 1'b1;

    if (tgt_o.stby && !cur_q.stby && cur_q.mute && min_ok_i)
      nxt.stby = 1'b1;
    else if (!tgt_o.stby && cur_q.stby && !cur_q.sd)
      nxt.stby = 1'b0;

    if (tgt_o.mute)                                    nxt.mute = 1'b1;
    else if (cur_q.mute && !cur_q.stby && rel_ok_i)    nxt.mute = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= '{stby: 1'b1, mute: 1'b1, sd: 1'b0};
    else         cur_q <= nxt;
  end

  assign cur_o = cur_q;

  p_unmute_needs_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cur_q.mute |-> !cur_q.stby);
  p_unmute_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q.mute && !nxt.mute) |-> rel_ok_i);
  p_mute_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q.stby && !$past(cur_q.stby)) |-> $past(cur_q.mute));
  p_hold_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cur_q.stby && nxt.stby) |-> min_ok_i);
  p_sd_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q.sd && !$past(cur_q.sd)) |-> ($past(cur_q.stby) && $past(cur_q.mute)));
  p_sd_implies_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_q.sd |-> (cur_q.stby && cur_q.mute));
endmodule

// File: rtl/amp_pwr_seq.sv
module amp_pwr_seq
  import amp_pwr_seq_pkg::*;
#(
  parameter int unsigned REL_DLY  = 30,
  parameter int unsigned STBY_MIN = 5,
  parameter int unsigned PUMP_DLY = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic stby_req_i,
  input  logic mute_req_i,
  input  logic sd_req_i,
  output logic stby_o,
  output logic mute_o,
  output logic sd_o,
  output logic pump_ready_o,
  output logic busy_o
);
  mode_t cur, tgt;
  logic  rel_ok, min_ok, pump_ok;

  amp_pwr_seq_timer #(
    .REL_DLY (REL_DLY),
    .STBY_MIN(STBY_MIN),
    .PUMP_DLY(PUMP_DLY)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .stby_i   (cur.stby),
    .rel_ok_o (rel_ok),
    .min_ok_o (min_ok),
    .pump_ok_o(pump_ok)
  );

  amp_pwr_seq_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stby_req_i(stby_req_i),
    .mute_req_i(mute_req_i),
    .sd_req_i  (sd_req_i),
    .rel_ok_i  (rel_ok),
    .min_ok_i  (min_ok),
    .cur_o     (cur),
    .tgt_o     (tgt)
  );

  assign stby_o       = cur.stby;
  assign mute_o       = cur.mute;
  assign sd_o         = cur.sd;
  assign pump_ready_o = !cur.stby && pump_ok;
  assign busy_o       = cur != tgt;

  p_ready_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stby_o |-> !pump_ready_o);
  p_idle_matches_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && sd_req_i) |-> (sd_o && stby_o && mute_o));
endmodule

// File: tb/amp_pwr_seq_tb.sv
`timescale 1ns/1ps
module amp_pwr_seq_tb;
  localparam int unsigned REL  = 6;
  localparam int unsigned SMIN = 3;
  localparam int unsigned PUMP = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick = 1'b0, stby_req = 1'b1, mute_req = 1'b1, sd_req = 1'b0;
  logic stby, mute, sd, rdy, busy;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  amp_pwr_seq #(.REL_DLY(REL), .STBY_MIN(SMIN), .PUMP_DLY(PUMP)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick),
    .stby_req_i(stby_req), .mute_req_i(mute_req), .sd_req_i(sd_req),
    .stby_o(stby), .mute_o(mute), .sd_o(sd), .pump_ready_o(rdy), .busy_o(busy)
  );

  typedef struct packed {
    logic       stby, mute, sd;
    logic [3:0] ticks;
    logic [4:0] exp;  // {stby, mute, sd, ready, busy}
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b0, 4'd0, 5'b01001},  // R2 release, mute held
    '{1'b0, 1'b0, 1'b0, 4'd2, 5'b01011},  // R7 pump ready
    '{1'b0, 1'b0, 1'b0, 4'd3, 5'b01011},  // R3 one tick short
    '{1'b0, 1'b0, 1'b0, 4'd1, 5'b00010},  // R3 window done, R8 idle
    '{1'b1, 1'b0, 1'b0, 4'd0, 5'b11000},  // R4 mute then standby
    '{1'b0, 1'b0, 1'b0, 4'd0, 5'b01001},  // R2 release again
    '{1'b1, 1'b1, 1'b0, 4'd2, 5'b01011},  // R5 hold window pending
    '{1'b1, 1'b1, 1'b0, 4'd1, 5'b11000},  // R5 applied on expiry
    '{1'b0, 1'b1, 1'b0, 4'd6, 5'b01010},  // R4 requested mute kept
    '{1'b0, 1'b0, 1'b1, 4'd0, 5'b11100},  // R6 shutdown
    '{1'b0, 1'b0, 1'b0, 4'd6, 5'b00010},  // R6 leave shutdown
    '{1'b0, 1'b0, 1'b1, 4'd0, 5'b11100},  // R6 shutdown from running
    '{1'b0, 1'b0, 1'b0, 4'd0, 5'b01001},  // R6 release after sd clears
    '{1'b0, 1'b0, 1'b1, 4'd1, 5'b01001},  // R5 shutdown waits hold
    '{1'b0, 1'b0, 1'b1, 4'd2, 5'b11100}   // R6 shutdown completes
  };

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {stby,mute,sd,ready,busy} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic pulse_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      repeat (3) @(posedge clk);
    end
  endtask

  function automatic logic [4:0] outs();
    return {stby, mute, sd, rdy, busy};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 in reset", outs(), 5'b11000);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 after reset", outs(), 5'b11000);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      stby_req = VECS[v].stby; mute_req = VECS[v].mute; sd_req = VECS[v].sd;
      repeat (4) @(posedge clk);
      pulse_ticks(int'(VECS[v].ticks));
      repeat (4) @(posedge clk);
      @(negedge clk);
      check($sformatf("vector %0d", v), outs(), VECS[v].exp);
    end

    // running state, then shutdown order edge by edge (R6, R7)
    @(negedge clk);
    sd_req = 1'b0; stby_req = 1'b0; mute_req = 1'b0;
    repeat (4) @(posedge clk);
    pulse_ticks(REL);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R3 running", outs(), 5'b00010);
    sd_req = 1'b1;
    @(negedge clk);
    check("R6 mute first", outs(), 5'b01011);
    @(negedge clk);
    check("R6 standby second, R7 ready drops", outs(), 5'b11001);
    @(negedge clk);
    check("R6 shutdown last", outs(), 5'b11100);
    sd_req = 1'b0;
    @(negedge clk);
    check("R6 sd clears first", outs(), 5'b11001);
    @(negedge clk);
    check("R2 standby released after sd", outs(), 5'b01001);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule